// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Unit

This unit moves data between a register file of 16-bit registers and a memory that is one byte wide. It serves a small CPU that stores words big-endian. A 16-bit register can be used whole, or as two separate 8-bit halves. The unit performs four operations: a word load, a word store, and a byte load into either the upper or the lower half of a register. A word access takes two byte cycles on the memory port, upper byte first. Every load recomputes the zero flag from the value that was actually fetched, so a byte load sees only its own byte.

An operation is launched with a one-cycle `start` that carries the operation code, register index and base address. The unit reads the source register through a combinational read port when the operation is accepted. It drives the memory port with a read or write strobe, and returns load results through a register write port that has a per-half write enable. `done` marks completion for exactly one cycle. Memory read data is expected one cycle after the read strobe.

Top module: `be_lsu`

## Requirements
- R1: While and just after reset, `done`, `mem_we`, `mem_re` and `rf_wr_en` are low and `z_flag` is 0.
- R2: Operation code 2'b00 (word load) reads address A and then A+1. It writes the register with the byte from A in bits 15:8 and the byte from A+1 in bits 7:0, with write mask 2'b11.
- R3: Operation code 2'b01 (word store) writes bits 15:8 of the register to address A in one cycle and bits 7:0 to A+1 in the next. The two bytes are written separately, and read and write strobes are never high together.
- R4: A word load sets `z_flag` to 1 exactly when the loaded 16-bit value is zero, and to 0 otherwise.
- R5: Operation code 2'b10 (upper byte load) writes the byte read from A into bits 15:8 only (mask 2'b10). `z_flag` then reflects only that byte, whatever bits 7:0 hold.
- R6: Operation code 2'b11 (lower byte load) writes the byte read from A into bits 7:0 only (mask 2'b01). `z_flag` reflects only that byte.
- R7: A word store leaves `z_flag` unchanged, and `z_flag` changes only on the register write of a load.
- R8: `done` is high for one cycle. Counting the clock edge that accepts `start` as edge 1, `done` is high after edge 3 for word operations and after edge 2 for byte loads. The register write happens only in the `done` cycle.
- R9: A `start` that arrives while an operation is in progress is ignored. It causes no memory access, no register write and no extra `done`.
- R10: The second byte address of a word access is A+1 modulo 2^ADDR_W, so base address all-ones wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation (accepted only when idle) |
| op | input | 2 | Operation code: 00 word load, 01 word store, 10 upper byte load, 11 lower byte load |
| reg_sel | input | REG_AW | Register index for the operation |
| base_addr | input | ADDR_W | Base byte address A |
| done | output | 1 | One-cycle completion pulse |
| z_flag | output | 1 | Zero status flag |
| rf_rd_idx | output | REG_AW | Register read index (follows `reg_sel`) |
| rf_rd_data | input | 16 | Register read data, combinational |
| rf_wr_en | output | 1 | Register write enable |
| rf_wr_idx | output | REG_AW | Register write index |
| rf_wr_half | output | 2 | Half write mask: bit 1 enables bits 15:8, bit 0 enables bits 7:0 |
| rf_wr_data | output | 16 | Register write data |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_re` |

## Verification
For a word operation, `done` is due after the third clock edge, counting the edge that accepts `start`. For a byte load it is due after the second. The register contents and `z_flag` are due one edge after `done`. Each task drives `start` on a falling edge and counts falling edges until `done` appears, so the latency is measured rather than assumed. The register model and `z_flag` are read on the falling edge after `done`. Memory writes are logged on each rising edge in issue order, so the bench can check both the byte order and the addresses of a store.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_LDW  = 2'b00,
        OP_STW  = 2'b01,
        OP_LDBH = 2'b10,
        OP_LDBL = 2'b11
    } lsu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_FIRST  = 2'b01,
        ST_SECOND = 2'b10,
        ST_FINISH = 2'b11
    } lsu_state_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } half_mask_t;

    function automatic logic op_is_load(lsu_op_e o);
        return o != OP_STW;
    endfunction

    function automatic logic op_is_word(lsu_op_e o);
        return (o == OP_LDW) || (o == OP_STW);
    endfunction

    function automatic half_mask_t op_mask(lsu_op_e o);
        half_mask_t m;
        case (o)
            OP_LDW:  m = '{hi: 1'b1, lo: 1'b1};
            OP_LDBH: m = '{hi: 1'b1, lo: 1'b0};
            OP_LDBL: m = '{hi: 1'b0, lo: 1'b1};
            default: m = '{hi: 1'b0, lo: 1'b0};
        endcase
        return m;
    endfunction

    function automatic logic [BYTE_W-1:0] word_byte(logic [WORD_W-1:0] w, logic upper);
        return upper ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
    import be_lsu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  lsu_op_e           op_in,
    input  logic [REG_AW-1:0] reg_in,
    input  logic [ADDR_W-1:0] addr_in,
    output lsu_state_e        state_o,
    output lsu_op_e           op_o,
    output logic [REG_AW-1:0] reg_o,
    output logic              accept_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_re_o,
    output logic              mem_we_o
);

    localparam logic [ADDR_W-1:0] ADDR_STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

    lsu_state_e        state_q, state_d;
    lsu_op_e           op_q;
    logic [REG_AW-1:0] reg_q;
    logic [ADDR_W-1:0] base_q;
    logic              active;

    assign accept_o = (state_q == ST_IDLE) && start;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (start) state_d = ST_FIRST;
            ST_FIRST:  state_d = op_is_word(op_q) ? ST_SECOND : ST_FINISH;
            ST_SECOND: state_d = ST_FINISH;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_LDW;
            reg_q   <= '0;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept_o) begin
                op_q   <= op_in;
                reg_q  <= reg_in;
                base_q <= addr_in;
            end
        end
    end

    assign active     = (state_q == ST_FIRST) || (state_q == ST_SECOND);
    assign mem_addr_o = (state_q == ST_SECOND) ? base_q + ADDR_STEP : base_q;
    assign mem_re_o   = active && op_is_load(op_q);
    assign mem_we_o   = active && !op_is_load(op_q);
    assign state_o    = state_q;
    assign op_o       = op_q;
    assign reg_o      = reg_q;

endmodule

// File: rtl/lsu_lane.sv
module lsu_lane
    import be_lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [WORD_W-1:0] src_word,
    input  lsu_state_e        state,
    input  lsu_op_e           op,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              wr_en,
    output half_mask_t        wr_mask,
    output logic [WORD_W-1:0] wr_data,
    output logic              load_zero
);

    logic [WORD_W-1:0] store_q;
    logic [BYTE_W-1:0] upper_q;
    logic              word_op;

    assign word_op = op_is_word(op);

    // Store word is captured at accept; upper byte of a word load is
    // captured when its read data returns, during the second byte cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
            upper_q <= '0;
        end else begin
            if (accept) store_q <= src_word;
            if (state == ST_SECOND && op == OP_LDW) upper_q <= mem_rdata;
        end
    end

    // Big-endian order: upper byte goes out in the first cycle.
    assign mem_wdata = word_byte(store_q, state != ST_SECOND);

    assign wr_en   = (state == ST_FINISH) && op_is_load(op);
    assign wr_mask = wr_en ? op_mask(op) : '{hi: 1'b0, lo: 1'b0};
    assign wr_data = word_op ? {upper_q, mem_rdata} : {mem_rdata, mem_rdata};

    assign load_zero = word_op ? ({upper_q, mem_rdata} == '0) : (mem_rdata == '0);

endmodule

// File: rtl/lsu_zflag.sv
module lsu_zflag (
    input  logic clk,
    input  logic rst,
    input  logic update,
    input  logic zero_in,
    output logic z_out
);

    always_ff @(posedge clk) begin
        if (rst)         z_out <= 1'b0;
        else if (update) z_out <= zero_in;
    end

endmodule

// File: rtl/be_lsu.sv
module be_lsu
    import be_lsu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [REG_AW-1:0] reg_sel,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              done,
    output logic              z_flag,
    output logic [REG_AW-1:0] rf_rd_idx,
    input  logic [15:0]       rf_rd_data,
    output logic              rf_wr_en,
    output logic [REG_AW-1:0] rf_wr_idx,
    output logic [1:0]        rf_wr_half,
    output logic [15:0]       rf_wr_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata
);

    lsu_state_e state;
    lsu_op_e    op_q;
    logic       accept;
    half_mask_t mask;
    logic       load_zero;

    lsu_ctrl #(
        .ADDR_W(ADDR_W),
        .REG_AW(REG_AW)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op_in     (lsu_op_e'(op)),
        .reg_in    (reg_sel),
        .addr_in   (base_addr),
        .state_o   (state),
        .op_o      (op_q),
        .reg_o     (rf_wr_idx),
        .accept_o  (accept),
        .mem_addr_o(mem_addr),
        .mem_re_o  (mem_re),
        .mem_we_o  (mem_we)
    );

    lsu_lane lane_i (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .src_word (rf_rd_data),
        .state    (state),
        .op       (op_q),
        .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata),
        .wr_en    (rf_wr_en),
        .wr_mask  (mask),
        .wr_data  (rf_wr_data),
        .load_zero(load_zero)
    );

    lsu_zflag zflag_i (
        .clk    (clk),
        .rst    (rst),
        .update (rf_wr_en),
        .zero_in(load_zero),
        .z_out  (z_flag)
    );

    assign rf_rd_idx  = reg_sel;
    assign rf_wr_half = {mask.hi, mask.lo};
    assign done       = (state == ST_FINISH);

endmodule

// File: rtl/be_lsu_chk.sv
module be_lsu_chk #(
    parameter int ADDR_W = 8,
    parameter int REG_AW = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic              z_flag,
    input logic              rf_wr_en,
    input logic [REG_AW-1:0] rf_wr_idx,
    input logic [1:0]        rf_wr_half,
    input logic [15:0]       rf_wr_data,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_re
);

    localparam logic [ADDR_W-1:0] STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!done && !mem_we && !mem_re && !rf_wr_en && !z_flag));

    assert_no_dual_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    assert_next_byte_addr_R10: assert property (@(posedge clk) disable iff (rst)
        ((mem_we || mem_re) && $past(mem_we || mem_re)) |-> (mem_addr == $past(mem_addr) + STEP));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_write_at_done_R8: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en |-> (done && rf_wr_half != 2'b00 && !$isunknown(rf_wr_idx)));

    assert_z_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !rf_wr_en |=> $stable(z_flag));

    assert_word_z_R4: assert property (@(posedge clk) disable iff (rst)
        (rf_wr_en && rf_wr_half == 2'b11) |=> (z_flag == ($past(rf_wr_data) == 16'h0000)));

    assert_upper_z_R5: assert property (@(posedge clk) disable iff (rst)
        (rf_wr_en && rf_wr_half == 2'b10) |=> (z_flag == ($past(rf_wr_data[15:8]) == 8'h00)));

    assert_lower_z_R6: assert property (@(posedge clk) disable iff (rst)
        (rf_wr_en && rf_wr_half == 2'b01) |=> (z_flag == ($past(rf_wr_data[7:0]) == 8'h00)));

endmodule

bind be_lsu be_lsu_chk #(
    .ADDR_W(ADDR_W),
    .REG_AW(REG_AW)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .z_flag    (z_flag),
    .rf_wr_en  (rf_wr_en),
    .rf_wr_idx (rf_wr_idx),
    .rf_wr_half(rf_wr_half),
    .rf_wr_data(rf_wr_data),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re)
);

// File: tb/be_lsu_tb_top.sv
module be_lsu_tb_top;

    localparam int ADDR_W = 8;
    localparam int REG_AW = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [1:0]        op = 2'b00;
    logic [REG_AW-1:0] reg_sel = '0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic              done, z_flag, rf_wr_en, mem_we, mem_re;
    logic [REG_AW-1:0] rf_rd_idx, rf_wr_idx;
    logic [1:0]        rf_wr_half;
    logic [15:0]       rf_wr_data, rf_rd_data;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata = 8'h00;

    logic [15:0] regs [1<<REG_AW];
    logic [7:0]  mem  [1<<ADDR_W];

    int applied = 0;
    int failed  = 0;
    int wr_cnt  = 0;
    int done_cnt = 0;
    logic [ADDR_W-1:0] wr_addr [4];
    logic [7:0]        wr_byte [4];

    always #4 clk = ~clk;

    be_lsu #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .op(op), .reg_sel(reg_sel),
        .base_addr(base_addr), .done(done), .z_flag(z_flag),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en),
        .rf_wr_idx(rf_wr_idx), .rf_wr_half(rf_wr_half), .rf_wr_data(rf_wr_data),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    assign rf_rd_data = regs[rf_rd_idx];

    // Memory and register file models
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr];
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            if (wr_cnt < 4) begin
                wr_addr[wr_cnt] <= mem_addr;
                wr_byte[wr_cnt] <= mem_wdata;
            end
            wr_cnt <= wr_cnt + 1;
        end
        if (done) done_cnt <= done_cnt + 1;
        if (rf_wr_en) begin
            if (rf_wr_half[1]) regs[rf_wr_idx][15:8] <= rf_wr_data[15:8];
            if (rf_wr_half[0]) regs[rf_wr_idx][7:0]  <= rf_wr_data[7:0];
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Launch one operation, return the falling edges until done.
    task automatic run_op(input logic [1:0] o, input logic [REG_AW-1:0] r,
                          input logic [ADDR_W-1:0] a, output int lat);
        @(negedge clk);
        wr_cnt = 0;
        done_cnt = 0;
        start = 1'b1; op = o; reg_sel = r; base_addr = a;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
    endtask

    task automatic t_reset;
        check(!done && !mem_we && !mem_re && !rf_wr_en, "R1 strobes idle",
              {28'd0, done, mem_we, mem_re, rf_wr_en}, 32'd0);
        check(z_flag == 1'b0, "R1 z after reset", z_flag, 0);
    endtask

    task automatic t_load_word(input logic [REG_AW-1:0] r, input logic [ADDR_W-1:0] a,
                               input logic [15:0] val);
        int lat;
        logic [ADDR_W-1:0] a1 = a + 1'b1;
        mem[a] = val[15:8];
        mem[a1] = val[7:0];
        regs[r] = 16'h5AC3;
        run_op(2'b00, r, a, lat);
        check(lat == 3, "R8 word load latency", lat, 3);
        check(regs[r] == val, "R2 word load value", regs[r], val);
        check(z_flag == (val == 16'h0), "R4 word load z", z_flag, val == 16'h0);
        check(wr_cnt == 0, "R2 no mem write on load", wr_cnt, 0);
    endtask

    task automatic t_store_word(input logic [REG_AW-1:0] r, input logic [ADDR_W-1:0] a,
                                input logic [15:0] val);
        int lat;
        logic z0 = z_flag;
        logic [ADDR_W-1:0] a1 = a + 1'b1;
        regs[r] = val;
        mem[a] = 8'hEE;
        mem[a1] = 8'hEE;
        run_op(2'b01, r, a, lat);
        check(lat == 3, "R8 word store latency", lat, 3);
        check(wr_cnt == 2, "R3 store write count", wr_cnt, 2);
        check(wr_addr[0] == a && wr_byte[0] == val[15:8], "R3 first store byte",
              {wr_addr[0], wr_byte[0]}, {a, val[15:8]});
        check(wr_addr[1] == a1 && wr_byte[1] == val[7:0], "R3 second store byte",
              {wr_addr[1], wr_byte[1]}, {a1, val[7:0]});
        check(z_flag == z0, "R7 store keeps z", z_flag, z0);
        check(done_cnt == 1, "R8 single done", done_cnt, 1);
    endtask

    task automatic t_load_byte(input logic upper, input logic [REG_AW-1:0] r,
                               input logic [ADDR_W-1:0] a, input logic [7:0] b,
                               input logic [15:0] init);
        int lat;
        logic [15:0] exp;
        mem[a] = b;
        regs[r] = init;
        exp = upper ? {b, init[7:0]} : {init[15:8], b};
        run_op(upper ? 2'b10 : 2'b11, r, a, lat);
        check(lat == 2, "R8 byte load latency", lat, 2);
        if (upper) begin
            check(regs[r] == exp, "R5 upper byte load", regs[r], exp);
            check(z_flag == (b == 8'h0), "R5 upper byte z", z_flag, b == 8'h0);
        end else begin
            check(regs[r] == exp, "R6 lower byte load", regs[r], exp);
            check(z_flag == (b == 8'h0), "R6 lower byte z", z_flag, b == 8'h0);
        end
    endtask

    task automatic t_busy_start;
        int lat;
        mem[8'h40] = 8'h9B;
        mem[8'h41] = 8'h07;
        regs[2] = 16'h0000;
        regs[5] = 16'hC0DE;
        @(negedge clk);
        wr_cnt = 0;
        done_cnt = 0;
        start = 1'b1; op = 2'b00; reg_sel = 3'd2; base_addr = 8'h40;
        @(negedge clk);
        start = 1'b1; op = 2'b01; reg_sel = 3'd5; base_addr = 8'h41;
        @(negedge clk);
        start = 1'b0;
        lat = 2;
        while (!done && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        repeat (4) @(negedge clk);
        check(lat == 3, "R9 latency with extra start", lat, 3);
        check(wr_cnt == 0, "R9 ignored store wrote memory", wr_cnt, 0);
        check(done_cnt == 1, "R9 extra done pulse", done_cnt, 1);
        check(regs[2] == 16'h9B07, "R9 load unaffected", regs[2], 16'h9B07);
        check(mem[8'h41] == 8'h07, "R9 memory untouched", mem[8'h41], 8'h07);
    endtask

    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = 8'(i * 7 + 3);
        for (int i = 0; i < (1 << REG_AW); i++) regs[i] = 16'h1111 * 16'(i);
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        @(negedge clk);
        t_reset;

        t_load_word(3'd1, 8'h10, 16'h12A4);
        t_load_word(3'd2, 8'h20, 16'h00FF);
        t_load_word(3'd3, 8'h30, 16'hFF00);
        t_load_word(3'd4, 8'h50, 16'h0000);   // z goes to 1
        t_store_word(3'd5, 8'h60, 16'h12A4);  // R7: z stays 1
        t_load_word(3'd6, 8'hFF, 16'h5C3B);   // R10 wrap, z goes to 0
        t_store_word(3'd7, 8'h70, 16'h0000);  // R7: z stays 0
        t_store_word(3'd0, 8'hFF, 16'hA41E);  // R10 store wrap
        check(mem[8'hFF] == 8'hA4 && mem[8'h00] == 8'h1E, "R10 wrapped store",
              {mem[8'hFF], mem[8'h00]}, 16'hA41E);

        t_load_byte(1'b1, 3'd1, 8'h80, 8'h00, 16'h00A4); // upper zero, low nonzero
        t_load_byte(1'b1, 3'd2, 8'h81, 8'h7E, 16'h0000); // upper nonzero, low zero
        t_load_byte(1'b0, 3'd3, 8'h82, 8'h00, 16'h3400);
        t_load_byte(1'b0, 3'd4, 8'h83, 8'hC1, 16'h0000);

        t_busy_start;

        $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
        $finish;
    end

    initial begin
        #(8 * 100000);
        failed++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
        $finish;
    end

endmodule